// File: doc/BRIEF.md
# PCIe Root-Port Bring-Up Sequencer

This block is a hardware state machine that powers up a PCIe root-port controller and its PHYs from a single start pulse. It drives the power, reset and clock controls in a fixed order. It waits a programmable number of cycles around the card reset and again before the PHY register accesses. It then issues one lane-configuration write per lane of every PHY through an external control-register write master. Finally it releases the link-training hold, selects root-complex mode and enables link training. A write timeout reported by the external master stops the sequence with link training left disabled.

The state machine walks through these states in order, one cycle each unless noted:
- `S_IDLE`: waits for `start_i`.
- `S_ASSERT_RST`: returns every control output to its reset value.
- `S_POWER_ON`: enables power and loads the card-reset delay.
- `S_PERST_WAIT`: waits `PERST_DLY` cycles.
- `S_PERST_REL`: releases the card reset.
- `S_POR_REL`: releases the core power-on reset.
- `S_AUXCLK_ON`, `S_HOLD_PHY`, `S_AUXRST_REL`: turn the auxiliary clock on, assert the PHY hold, and release the auxiliary reset.
- `S_CR_SEL`: selects the PHY register port of every PHY and loads the settle delay.
- `S_SETTLE`: waits `SETTLE_DLY` cycles.
- `S_LANE_START`: launches the lane writes.
- `S_LANE_WAIT`: waits for the last write to complete or for a timeout.
- `S_AUXCLK_OFF`, `S_HOLD_REL`, `S_AUXCLK_RE`: gate the auxiliary clock off, release the PHY hold, and turn the auxiliary clock back on.
- `S_DEVTYPE`: writes the root-complex device type.
- `S_LTSSM_ON`: enables link training.
- `S_DONE`: raises the done pulse, then returns to `S_IDLE`.

The transitions are:
- `S_IDLE` goes to `S_ASSERT_RST` on `start_i`.
- `S_PERST_WAIT` and `S_SETTLE` leave when the shared delay timer reaches zero.
- `S_LANE_WAIT` goes to `S_AUXCLK_OFF` when the last write completes.
- `S_LANE_WAIT` goes to `S_FAIL` on a timeout. `S_FAIL` sets the sticky error flag and returns to `S_IDLE`.
- Every other state goes to the next state in the list above.

A combinational decoder reports link-up from a status word.

Top module: `pcie_bringup_seq`

## Requirements
- R1: While `rst_n` is low, the outputs take their reset values: `core_por_n_o`=0, `card_rst_n_o`=0, `pwr_en_o`=0, `aux_clk_en_o`=0, `aux_rst_o`=1, `hold_phy_rst_o`=0, `ltssm_en_o`=0, `cr_sel_o`=0, `dev_type_o`=0, `wr_req_o`=0, `busy_o`=0, `done_o`=0, `error_o`=0.
- R2: An accepted start first returns all control outputs to their R1 values, and only after that raises `pwr_en_o`. `card_rst_n_o` is never high while `pwr_en_o` is low.
- R3: `card_rst_n_o` rises between `PERST_DLY` and `PERST_DLY`+2 cycles after `pwr_en_o` rises. `core_por_n_o` rises after `card_rst_n_o`.
- R4: After the core reset is released, the outputs change in this order: `aux_clk_en_o` rises, `hold_phy_rst_o` rises, `aux_rst_o` falls, and `cr_sel_o` becomes all ones. The first `wr_req_o` rises at least `SETTLE_DLY` cycles after `cr_sel_o` becomes all ones.
- R5: The writes go out PHY by PHY, with lanes 0 to 3 in order within each PHY.
  - Each write carries data 0x0E21, which has bits 0, 5, 9, 10 and 11 set.
  - Each write's address is 0x1008 + 0x100 × lane.
  - `wr_req_o` stays high with a stable address until `wr_done_i` or `wr_timeout_i`.
  - A request occurs only while `hold_phy_rst_o` is high.
- R6: After the last write, the outputs change in this order: `aux_clk_en_o` falls, `hold_phy_rst_o` falls, `aux_clk_en_o` rises, `dev_type_o` becomes 4, and finally `ltssm_en_o` rises.
- R7: `busy_o` is high from the cycle after an accepted start until the one-cycle `done_o` pulse, and low in the cycle after it.
- R8: A `wr_timeout_i` during the lane writes has these effects:
  - the sequence stops and no further write is requested;
  - `error_o` is set and stays set until the next accepted start;
  - `ltssm_en_o` stays 0 and `busy_o` drops.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: `link_up_o` is high only when `link_status_i` bit 4 is 1 and bit 29 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start_i | input | 1 | start pulse |
| link_status_i | input | STATUS_W | controller debug status word |
| wr_done_i | input | 1 | write master completed the current write |
| wr_timeout_i | input | 1 | write master timed out on the current write |
| core_por_n_o | output | 1 | core power-on reset, active low |
| card_rst_n_o | output | 1 | card reset, active low |
| pwr_en_o | output | 1 | slot power enable |
| aux_clk_en_o | output | 1 | auxiliary clock enable |
| aux_rst_o | output | 1 | auxiliary reset, active high |
| hold_phy_rst_o | output | 1 | holds the link-training logic in reset |
| cr_sel_o | output | NUM_PHY | PHY register-port select, one bit per PHY |
| ltssm_en_o | output | 1 | link-training enable |
| dev_type_o | output | DEV_TYPE_W | device type field (4 = root complex) |
| wr_req_o | output | 1 | lane write request |
| wr_phy_o | output | PHY_W | target PHY of the write |
| wr_addr_o | output | ADDR_W | PHY register address |
| wr_data_o | output | DATA_W | write data |
| busy_o | output | 1 | sequence in progress |
| done_o | output | 1 | one-cycle completion pulse |
| error_o | output | 1 | sticky timeout error |
| link_up_o | output | 1 | link up and not training |

## Verification
Most internal faults of this block show up as a wrong order of edges on the power, reset and clock outputs. For example, a skipped or reordered state moves a change out of place in the stream of output snapshots, and the stream shows this on the very edge that breaks the order. A miscounted delay shows at the next edge of `card_rst_n_o` or at the first `wr_req_o` rise, as a gap outside the allowed window. Wrong lane indexing appears on the first write whose PHY, address or data differs. A lost error state shows within a few cycles of the timeout: either `ltssm_en_o` rises, or `error_o` stays low when `busy_o` falls.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_ASSERT_RST,
        S_POWER_ON,
        S_PERST_WAIT,
        S_PERST_REL,
        S_POR_REL,
        S_AUXCLK_ON,
        S_HOLD_PHY,
        S_AUXRST_REL,
        S_CR_SEL,
        S_SETTLE,
        S_LANE_START,
        S_LANE_WAIT,
        S_AUXCLK_OFF,
        S_HOLD_REL,
        S_AUXCLK_RE,
        S_DEVTYPE,
        S_LTSSM_ON,
        S_DONE,
        S_FAIL
    } seq_state_e;

    // Lane configuration bits
    localparam int unsigned LANE_CDR_TRACK_BIT = 0;
    localparam int unsigned LANE_LOS_LVL_BIT   = 5;
    localparam int unsigned LANE_TERM_ON_BIT   = 9;
    localparam int unsigned LANE_TERM_AC_BIT   = 10;
    localparam int unsigned LANE_ENABLE_BIT    = 11;

    localparam int unsigned LANE_INIT_VAL =
        (1 << LANE_CDR_TRACK_BIT) | (1 << LANE_LOS_LVL_BIT) |
        (1 << LANE_TERM_ON_BIT)   | (1 << LANE_TERM_AC_BIT) |
        (1 << LANE_ENABLE_BIT);

    localparam int unsigned LANE_REG_BASE   = 'h1008;
    localparam int unsigned LANE_REG_STRIDE = 'h100;
    localparam int unsigned DEV_TYPE_ROOT   = 4;

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lane_cfg_issuer.sv
module lane_cfg_issuer #(
    parameter int          NUM_PHY       = 2,
    parameter int          LANES_PER_PHY = 4,
    parameter int          PHY_W         = 1,
    parameter int          ADDR_W        = 16,
    parameter int          DATA_W        = 16,
    parameter int unsigned ADDR_BASE     = 'h1008,
    parameter int unsigned ADDR_STRIDE   = 'h100,
    parameter int unsigned INIT_WORD     = 'hE21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              wr_done_i,
    input  logic              wr_timeout_i,
    output logic              wr_req_o,
    output logic [PHY_W-1:0]  wr_phy_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              all_done_o,
    output logic              fail_o
);

    localparam int LANE_W = (LANES_PER_PHY > 1) ? $clog2(LANES_PER_PHY) : 1;

    logic              active_q;
    logic [PHY_W-1:0]  phy_q;
    logic [LANE_W-1:0] lane_q;
    logic              last_lane;
    logic              last_phy;
    logic [ADDR_W-1:0] lane_addr [LANES_PER_PHY];

    for (genvar l = 0; l < LANES_PER_PHY; l++) begin : g_lane_addr
        assign lane_addr[l] = ADDR_W'(ADDR_BASE + l * ADDR_STRIDE);
    end

    assign last_lane = (lane_q == LANE_W'(LANES_PER_PHY - 1));
    assign last_phy  = (phy_q == PHY_W'(NUM_PHY - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phy_q    <= '0;
            lane_q   <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            phy_q    <= '0;
            lane_q   <= '0;
        end else if (active_q) begin
            if (wr_timeout_i) begin
                active_q <= 1'b0;
            end else if (wr_done_i) begin
                if (last_lane && last_phy) begin
                    active_q <= 1'b0;
                end else if (last_lane) begin
                    lane_q <= '0;
                    phy_q  <= phy_q + 1'b1;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    assign wr_req_o   = active_q;
    assign wr_phy_o   = phy_q;
    assign wr_addr_o  = lane_addr[lane_q];
    assign wr_data_o  = DATA_W'(INIT_WORD);
    assign all_done_o = active_q && !wr_timeout_i && wr_done_i && last_lane && last_phy;
    assign fail_o     = active_q && wr_timeout_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_done_i && !wr_timeout_i) |=>
        (wr_req_o && $stable(wr_addr_o) && $stable(wr_phy_o))); // R5

endmodule

// File: rtl/link_state_decode.sv
module link_state_decode #(
    parameter int STATUS_W  = 32,
    parameter int UP_BIT    = 4,
    parameter int TRAIN_BIT = 29
) (
    input  logic [STATUS_W-1:0] status_i,
    output logic                link_up_o
);

    logic status_unused;

    assign link_up_o     = status_i[UP_BIT] && !status_i[TRAIN_BIT];
    assign status_unused = ^status_i;

endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
    import bringup_pkg::*;
#(
    parameter  int NUM_PHY        = 2,
    parameter  int LANES_PER_PHY  = 4,
    parameter  int PERST_DLY      = 100,
    parameter  int SETTLE_DLY     = 8,
    parameter  int ADDR_W         = 16,
    parameter  int DATA_W         = 16,
    parameter  int DEV_TYPE_W     = 4,
    parameter  int STATUS_W       = 32,
    parameter  int LINK_UP_BIT    = 4,
    parameter  int LINK_TRAIN_BIT = 29,
    localparam int PHY_W          = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [STATUS_W-1:0]   link_status_i,
    input  logic                  wr_done_i,
    input  logic                  wr_timeout_i,
    output logic                  core_por_n_o,
    output logic                  card_rst_n_o,
    output logic                  pwr_en_o,
    output logic                  aux_clk_en_o,
    output logic                  aux_rst_o,
    output logic                  hold_phy_rst_o,
    output logic [NUM_PHY-1:0]    cr_sel_o,
    output logic                  ltssm_en_o,
    output logic [DEV_TYPE_W-1:0] dev_type_o,
    output logic                  wr_req_o,
    output logic [PHY_W-1:0]      wr_phy_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  error_o,
    output logic                  link_up_o
);

    localparam int MAX_DLY = (PERST_DLY > SETTLE_DLY) ? PERST_DLY : SETTLE_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    seq_state_e       state_q, state_d;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             lane_go, lanes_done, lanes_fail;

    // Delay timer shared by both wait states
    assign tmr_load = (state_q == S_POWER_ON) || (state_q == S_CR_SEL);
    assign tmr_val  = (state_q == S_CR_SEL) ? CNT_W'(SETTLE_DLY - 1) : CNT_W'(PERST_DLY - 1);

    seq_delay_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    assign lane_go = (state_q == S_LANE_START);

    lane_cfg_issuer #(
        .NUM_PHY       (NUM_PHY),
        .LANES_PER_PHY (LANES_PER_PHY),
        .PHY_W         (PHY_W),
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .ADDR_BASE     (LANE_REG_BASE),
        .ADDR_STRIDE   (LANE_REG_STRIDE),
        .INIT_WORD     (LANE_INIT_VAL)
    ) i_issuer (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (lane_go),
        .wr_done_i    (wr_done_i),
        .wr_timeout_i (wr_timeout_i),
        .wr_req_o     (wr_req_o),
        .wr_phy_o     (wr_phy_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .all_done_o   (lanes_done),
        .fail_o       (lanes_fail)
    );

    link_state_decode #(
        .STATUS_W  (STATUS_W),
        .UP_BIT    (LINK_UP_BIT),
        .TRAIN_BIT (LINK_TRAIN_BIT)
    ) i_link (
        .status_i  (link_status_i),
        .link_up_o (link_up_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start_i) state_d = S_ASSERT_RST;
            S_ASSERT_RST: state_d = S_POWER_ON;
            S_POWER_ON:   state_d = S_PERST_WAIT;
            S_PERST_WAIT: if (tmr_zero) state_d = S_PERST_REL;
            S_PERST_REL:  state_d = S_POR_REL;
            S_POR_REL:    state_d = S_AUXCLK_ON;
            S_AUXCLK_ON:  state_d = S_HOLD_PHY;
            S_HOLD_PHY:   state_d = S_AUXRST_REL;
            S_AUXRST_REL: state_d = S_CR_SEL;
            S_CR_SEL:     state_d = S_SETTLE;
            S_SETTLE:     if (tmr_zero) state_d = S_LANE_START;
            S_LANE_START: state_d = S_LANE_WAIT;
            S_LANE_WAIT: begin
                if (lanes_fail) begin
                    state_d = S_FAIL;
                end else if (lanes_done) begin
                    state_d = S_AUXCLK_OFF;
                end
            end
            S_AUXCLK_OFF: state_d = S_HOLD_REL;
            S_HOLD_REL:   state_d = S_AUXCLK_RE;
            S_AUXCLK_RE:  state_d = S_DEVTYPE;
            S_DEVTYPE:    state_d = S_LTSSM_ON;
            S_LTSSM_ON:   state_d = S_DONE;
            S_DONE:       state_d = S_IDLE;
            S_FAIL:       state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // Output registers, updated by the state being left
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_por_n_o   <= 1'b0;
            card_rst_n_o   <= 1'b0;
            pwr_en_o       <= 1'b0;
            aux_clk_en_o   <= 1'b0;
            aux_rst_o      <= 1'b1;
            hold_phy_rst_o <= 1'b0;
            cr_sel_o       <= '0;
            ltssm_en_o     <= 1'b0;
            dev_type_o     <= '0;
            error_o        <= 1'b0;
        end else begin
            unique case (state_q)
                S_ASSERT_RST: begin
                    core_por_n_o   <= 1'b0;
                    card_rst_n_o   <= 1'b0;
                    pwr_en_o       <= 1'b0;
                    aux_clk_en_o   <= 1'b0;
                    aux_rst_o      <= 1'b1;
                    hold_phy_rst_o <= 1'b0;
                    cr_sel_o       <= '0;
                    ltssm_en_o     <= 1'b0;
                    dev_type_o     <= '0;
                    error_o        <= 1'b0;
                end
                S_POWER_ON:   pwr_en_o       <= 1'b1;
                S_PERST_REL:  card_rst_n_o   <= 1'b1;
                S_POR_REL:    core_por_n_o   <= 1'b1;
                S_AUXCLK_ON:  aux_clk_en_o   <= 1'b1;
                S_HOLD_PHY:   hold_phy_rst_o <= 1'b1;
                S_AUXRST_REL: aux_rst_o      <= 1'b0;
                S_CR_SEL:     cr_sel_o       <= '1;
                S_AUXCLK_OFF: aux_clk_en_o   <= 1'b0;
                S_HOLD_REL:   hold_phy_rst_o <= 1'b0;
                S_AUXCLK_RE:  aux_clk_en_o   <= 1'b1;
                S_DEVTYPE:    dev_type_o     <= DEV_TYPE_W'(DEV_TYPE_ROOT);
                S_LTSSM_ON:   ltssm_en_o     <= 1'b1;
                S_FAIL:       error_o        <= 1'b1;
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign done_o = (state_q == S_DONE);

    AST_PERST_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n_o |-> pwr_en_o); // R2
    AST_POR_AFTER_PERST: assert property (@(posedge clk) disable iff (!rst_n)
        core_por_n_o |-> card_rst_n_o); // R3
    AST_WRITE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> hold_phy_rst_o); // R5
    AST_LTSSM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en_o |-> (!hold_phy_rst_o && aux_clk_en_o &&
                        dev_type_o == DEV_TYPE_W'(DEV_TYPE_ROOT))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R7
    AST_ERR_NO_LTSSM: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !ltssm_en_o); // R8

endmodule

// File: tb/test_pcie_bringup_seq.sv
`timescale 1ns/1ps
module test_pcie_bringup_seq;

    localparam int PERST_DLY  = 100;
    localparam int SETTLE_DLY = 8;
    localparam int LAT        = 3;
    localparam int WDOG       = 150000;
    localparam logic [12:0] RST_SNAP = 13'b0_0_0_0_1_0_0_00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] link_status_i = '0;
    logic        wr_done_i = 1'b0;
    logic        wr_timeout_i = 1'b0;
    logic        core_por_n_o, card_rst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o;
    logic        hold_phy_rst_o, ltssm_en_o, wr_req_o, busy_o, done_o, error_o, link_up_o;
    logic [1:0]  cr_sel_o;
    logic [3:0]  dev_type_o;
    logic [0:0]  wr_phy_o;
    logic [15:0] wr_addr_o, wr_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fail_at = -1;
    int wr_index = 0;
    int lat_cnt = 0;
    int t_pwr = 0;
    int t_sel = -1;
    string snap_tag = "R6";
    logic [12:0] prev_snap;
    logic        prev_req;
    logic [12:0] exp_snap_q[$];
    logic [32:0] exp_wr_q[$];

    always #2 clk = ~clk;

    pcie_bringup_seq #(.PERST_DLY(PERST_DLY), .SETTLE_DLY(SETTLE_DLY)) i_pcie_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_status_i(link_status_i),
        .wr_done_i(wr_done_i), .wr_timeout_i(wr_timeout_i),
        .core_por_n_o(core_por_n_o), .card_rst_n_o(card_rst_n_o), .pwr_en_o(pwr_en_o),
        .aux_clk_en_o(aux_clk_en_o), .aux_rst_o(aux_rst_o), .hold_phy_rst_o(hold_phy_rst_o),
        .cr_sel_o(cr_sel_o), .ltssm_en_o(ltssm_en_o), .dev_type_o(dev_type_o),
        .wr_req_o(wr_req_o), .wr_phy_o(wr_phy_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .link_up_o(link_up_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [12:0] now_snap();
        return {core_por_n_o, card_rst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o,
                hold_phy_rst_o, ltssm_en_o, cr_sel_o, dev_type_o};
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL R7 watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: output-change scoreboard and delay windows
    always @(negedge clk) begin
        logic [12:0] cur;
        cur = now_snap();
        if (!rst_n) begin
            prev_snap = cur;
            prev_req  = wr_req_o;
        end else begin
            if (cur != prev_snap) begin
                if (exp_snap_q.size() == 0) begin
                    chk(1'b0, snap_tag, "unexpected output change", {51'd0, cur}, 64'd0);
                end else begin
                    logic [12:0] e;
                    e = exp_snap_q.pop_front();
                    chk(cur == e, snap_tag, "output snapshot", {51'd0, cur}, {51'd0, e});
                end
                if (cur[10] && !prev_snap[10]) t_pwr = cyc;
                if (cur[11] && !prev_snap[11])
                    chk((cyc - t_pwr) >= PERST_DLY && (cyc - t_pwr) <= PERST_DLY + 2,
                        "R3", "card reset hold", 64'(cyc - t_pwr), 64'(PERST_DLY));
                if (cur[5:4] == 2'b11 && prev_snap[5:4] == 2'b00) t_sel = cyc;
            end
            if (wr_req_o && !prev_req && t_sel >= 0) begin
                chk((cyc - t_sel) >= SETTLE_DLY, "R4", "settle gap",
                    64'(cyc - t_sel), 64'(SETTLE_DLY));
                t_sel = -1;
            end
            prev_snap = cur;
            prev_req  = wr_req_o;
        end
    end

    // External write master model
    always @(negedge clk) begin
        logic resp_pending;
        resp_pending = wr_done_i || wr_timeout_i;
        wr_done_i    <= 1'b0;
        wr_timeout_i <= 1'b0;
        if (rst_n && wr_req_o && !resp_pending) begin
            lat_cnt++;
            if (lat_cnt == LAT) begin
                logic [32:0] got;
                lat_cnt = 0;
                got = {wr_phy_o, wr_addr_o, wr_data_o};
                if (exp_wr_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", {31'd0, got}, 64'd0);
                end else begin
                    logic [32:0] e;
                    e = exp_wr_q.pop_front();
                    chk(got == e, "R5", "lane write", {31'd0, got}, {31'd0, e});
                end
                if (wr_index == fail_at) wr_timeout_i <= 1'b1;
                else                     wr_done_i    <= 1'b1;
                wr_index++;
            end
        end
    end

    // Driver: pushes expectations, then runs one sequence
    task automatic run_seq(input bit from_reset, input int fail_idx, input bit poke);
        logic [12:0] e;
        int n;
        int k;
        e = RST_SNAP;
        snap_tag = poke ? "R9" : "R6";
        if (!from_reset) exp_snap_q.push_back(e);
        e[10] = 1'b1;   exp_snap_q.push_back(e);
        e[11] = 1'b1;   exp_snap_q.push_back(e);
        e[12] = 1'b1;   exp_snap_q.push_back(e);
        e[9]  = 1'b1;   exp_snap_q.push_back(e);
        e[7]  = 1'b1;   exp_snap_q.push_back(e);
        e[8]  = 1'b0;   exp_snap_q.push_back(e);
        e[5:4] = 2'b11; exp_snap_q.push_back(e);
        if (fail_idx < 0) begin
            e[9]  = 1'b0;  exp_snap_q.push_back(e);
            e[7]  = 1'b0;  exp_snap_q.push_back(e);
            e[9]  = 1'b1;  exp_snap_q.push_back(e);
            e[3:0] = 4'd4; exp_snap_q.push_back(e);
            e[6]  = 1'b1;  exp_snap_q.push_back(e);
        end
        n = (fail_idx < 0) ? 8 : fail_idx + 1;
        k = 0;
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 4; l++) begin
                if (k < n) exp_wr_q.push_back({p[0], 16'(16'h1008 + 16'h100 * l), 16'h0E21});
                k++;
            end
        end
        fail_at  = fail_idx;
        wr_index = 0;
        lat_cnt  = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
        @(negedge clk);
        chk(error_o == 1'b0, "R8", "error cleared by start", 64'(error_o), 64'd0);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            start_i = poke && (i == 40);
            if (poke && i == 41)
                chk(busy_o == 1'b1, "R9", "busy kept after ignored start", 64'(busy_o), 64'd1);
            if (done_o) break;
            if (error_o && !busy_o) break;
        end
        start_i = 1'b0;
        if (fail_idx < 0) begin
            chk(done_o == 1'b1, "R7", "done pulse", 64'(done_o), 64'd1);
            chk(busy_o == 1'b1 && ltssm_en_o == 1'b1, "R6", "busy and ltssm at done",
                {62'd0, busy_o, ltssm_en_o}, 64'd3);
            @(negedge clk);
            chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "idle after done",
                {62'd0, busy_o, done_o}, 64'd0);
        end else begin
            chk(error_o == 1'b1, "R8", "error flag", 64'(error_o), 64'd1);
            chk(ltssm_en_o == 1'b0 && busy_o == 1'b0, "R8", "ltssm off, not busy",
                {62'd0, ltssm_en_o, busy_o}, 64'd0);
            repeat (20) @(negedge clk);
            chk(wr_req_o == 1'b0 && ltssm_en_o == 1'b0 && error_o == 1'b1, "R8",
                "stopped after timeout", {61'd0, wr_req_o, ltssm_en_o, error_o}, 64'd1);
        end
        repeat (4) @(negedge clk);
        chk(exp_snap_q.size() == 0, snap_tag, "missing output changes",
            64'(exp_snap_q.size()), 64'd0);
        chk(exp_wr_q.size() == 0, "R5", "missing writes", 64'(exp_wr_q.size()), 64'd0);
        exp_snap_q.delete();
        exp_wr_q.delete();
    endtask

    task automatic link_chk(input logic [31:0] st, input logic exp);
        link_status_i = st;
        #1;
        chk(link_up_o == exp, "R10", "link up decode", 64'(link_up_o), 64'(exp));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(now_snap() == RST_SNAP, "R1", "control outputs in reset",
            {51'd0, now_snap()}, {51'd0, RST_SNAP});
        chk({wr_req_o, busy_o, done_o, error_o} == 4'b0, "R1", "status outputs in reset",
            {60'd0, wr_req_o, busy_o, done_o, error_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(1'b1, -1, 1'b0);   // R2 R3 R4 R5 R6 R7 normal bring-up
        run_seq(1'b0, -1, 1'b1);   // R9 restart with a start pulse while busy
        run_seq(1'b0, 5, 1'b0);    // R8 timeout in the middle of the writes
        run_seq(1'b0, 0, 1'b0);    // R8 timeout on the first write
        run_seq(1'b0, -1, 1'b0);   // R2 recovery after an error
        link_chk(32'h0000_0010, 1'b1);
        link_chk(32'h2000_0010, 1'b0);
        link_chk(32'h0000_0000, 1'b0);
        link_chk(32'hFFFF_FFEF, 1'b0);
        link_chk(32'hDFFF_FFFF, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule